// File: doc/BRIEF.md
# CRC-32 Register-Mapped Calculation Unit

This block is a CRC-32 engine attached to a simple synchronous register bus. Software writes data into a data register and the engine folds those bits into a running checksum. Reading the same register returns the current checksum. A write may be a full word, a right-aligned half-word or a right-aligned byte, and the engine consumes exactly that many bits in one clock. The block also holds a general-purpose scratch word and a control register. The control register has a self-clearing bit that restarts the checksum.

The bus is request/response. The bus controller is a two-state machine. In state ST_IDLE it accepts a request (transition ACCEPT, to ST_RESP). In ST_RESP it drives `ready` high for one cycle with the read data and returns to ST_IDLE (transition RESPOND). A request seen while in ST_RESP is not taken. The access size comes from the byte strobes: `1111` is a word, `0011` is a half-word, `0001` is a byte, and every other pattern is an invalid size.

Top module: `crc_mmio_unit`

## Requirements
- R1: After reset, a word read of the data register (offset 0x00) returns 0xFFFFFFFF. Word reads of the scratch register (offset 0x04) and of the control register (offset 0x08) return 0.
- R2: Each accepted request gives exactly one `ready` pulse, one cycle long, in the cycle after acceptance. A request held high during that response cycle is not accepted as a second access.
- R3: A word write (`be`=1111) to offset 0x00 advances the checksum by all 32 bits of `wdata`, MSB first. The polynomial is 0x04C11DB7, with no reflection and no final XOR. The next data-register read returns the updated value.
- R4: A half-word write (`be`=0011) uses only `wdata[15:0]`, and a byte write (`be`=0001) uses only `wdata[7:0]`. Upper bits are ignored. Byte writes of the ASCII string "123456789" after a restart give 0x0376E6E7.
- R5: A half-word read of the data register returns the low 16 checksum bits, zero-extended. A byte read returns the low 8 bits, zero-extended.
- R6: An access to the data register with any strobe pattern other than 1111, 0011 or 0001 leaves the checksum unchanged on write and returns 0 on read.
- R7: The scratch register stores a word write and returns it on a word read. Non-word writes to it are ignored, and non-word reads of it return 0.
- R8: Writing 1 to control bit 0 reloads the checksum with 0xFFFFFFFF. The bit clears itself on the following cycle, so a later control read returns 0.
- R9: A restart through control bit 0 does not change the scratch register.
- R10: Writes to offset 0x0C or to any address with `addr[1:0]` not zero change nothing. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Byte address |
| wdata | input | 32 | Write data, right-aligned for narrow accesses |
| be | input | 4 | Byte strobes that give the access size |
| rdata | output | 32 | Read data, valid while ready is high (0 for writes) |
| ready | output | 1 | One-cycle response pulse |

## Verification
On every cycle, the assertions check the following. `ready` is a single-cycle pulse that follows a request. A pending restart leaves the checksum at 0xFFFFFFFF and clears itself. The scratch word and the checksum hold their values unless a qualifying write or restart occurs. The bench scenarios are needed to show that the checksum values are correct: word, half-word and byte updates against an independent model, the "123456789" check value, narrow read extraction, and that invalid sizes and unmapped addresses leave the state untouched.

// File: rtl/crc_mmio_pkg.sv
package crc_mmio_pkg;
    localparam int          WORD_W    = 32;
    localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;

    typedef enum logic [1:0] {SZ_WORD, SZ_HALF, SZ_BYTE, SZ_BAD} acc_size_e;
    typedef enum logic [1:0] {TGT_DATA, TGT_SCRATCH, TGT_CTRL, TGT_NONE} tgt_e;
    typedef enum logic {ST_IDLE, ST_RESP} bus_state_e;
endpackage

// File: rtl/crc_lane_engine.sv
module crc_lane_engine
    import crc_mmio_pkg::*;
#(
    parameter int          W      = WORD_W,
    parameter logic [W-1:0] POLY  = CRC_POLY,
    parameter int          NLANES = 3
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] data_in,
    input  acc_size_e    size,
    output logic [W-1:0] crc_out
);
    logic [NLANES-1:0][W-1:0] lane_res;

    // lane g consumes W >> g bits, MSB first
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LW = W >> g;
        logic [W-1:0] lane_c;
        always_comb begin
            logic fb;
            lane_c = crc_in;
            for (int i = LW - 1; i >= 0; i--) begin
                fb     = lane_c[W-1] ^ data_in[i];
                lane_c = {lane_c[W-2:0], 1'b0};
                if (fb) lane_c = lane_c ^ POLY;
            end
        end
        assign lane_res[g] = lane_c;
    end

    always_comb begin
        unique case (size)
            SZ_WORD: crc_out = lane_res[0];
            SZ_HALF: crc_out = lane_res[1];
            SZ_BYTE: crc_out = lane_res[2];
            default: crc_out = crc_in;
        endcase
    end
endmodule

// File: rtl/crc_bus_ctrl.sv
module crc_bus_ctrl
    import crc_mmio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output logic              accept,
    output tgt_e              tgt,
    output acc_size_e         size,
    output logic              ready
);
    bus_state_e state_q, state_d;
    logic       upper_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ACCEPT (idle -> resp), RESPOND (resp -> idle)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept = (state_q == ST_IDLE) && req;
        ready  = (state_q == ST_RESP);
    end

    // address width variant: extra upper bits must be zero
    if (ADDR_W > 4) begin : g_wide
        assign upper_zero = ~|addr[ADDR_W-1:4];
    end else begin : g_narrow
        assign upper_zero = 1'b1;
    end

    always_comb begin
        tgt = TGT_NONE;
        if (upper_zero && addr[1:0] == 2'b00) begin
            unique case (addr[3:2])
                2'd0:    tgt = TGT_DATA;
                2'd1:    tgt = TGT_SCRATCH;
                2'd2:    tgt = TGT_CTRL;
                default: tgt = TGT_NONE;
            endcase
        end
    end

    always_comb begin
        case (be)
            4'b1111: size = SZ_WORD;
            4'b0011: size = SZ_HALF;
            4'b0001: size = SZ_BYTE;
            default: size = SZ_BAD;
        endcase
    end

    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    // R2
    ready_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(req));
endmodule

// File: rtl/crc_reg_store.sv
module crc_reg_store
    import crc_mmio_pkg::*;
#(
    parameter int          W    = WORD_W,
    parameter logic [W-1:0] SEED = CRC_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  logic         we,
    input  tgt_e         tgt,
    input  acc_size_e    size,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] crc_next,
    output logic [W-1:0] crc_q,
    output logic [W-1:0] rdata
);
    localparam int HW = W / 2;
    localparam int BW = 8;

    logic [W-1:0] scr_q;
    logic         restart_q;
    logic [W-1:0] rd_val;
    logic         wr_data, wr_scr, wr_ctl;

    always_comb begin
        wr_data = accept && we && tgt == TGT_DATA    && size != SZ_BAD;
        wr_scr  = accept && we && tgt == TGT_SCRATCH && size == SZ_WORD;
        wr_ctl  = accept && we && tgt == TGT_CTRL    && size == SZ_WORD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         crc_q <= SEED;
        else if (restart_q) crc_q <= SEED;
        else if (wr_data)   crc_q <= crc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) restart_q <= 1'b0;
        else        restart_q <= wr_ctl && wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      scr_q <= '0;
        else if (wr_scr) scr_q <= wdata;
    end

    always_comb begin
        rd_val = '0;
        unique case (tgt)
            TGT_DATA: begin
                unique case (size)
                    SZ_WORD: rd_val = crc_q;
                    SZ_HALF: rd_val = {{(W-HW){1'b0}}, crc_q[HW-1:0]};
                    SZ_BYTE: rd_val = {{(W-BW){1'b0}}, crc_q[BW-1:0]};
                    default: rd_val = '0;
                endcase
            end
            TGT_SCRATCH: rd_val = (size == SZ_WORD) ? scr_q : '0;
            TGT_CTRL:    rd_val = (size == SZ_WORD) ? {{(W-1){1'b0}}, restart_q} : '0;
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (accept) rdata <= we ? '0 : rd_val;
    end

    // R8
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |=> (crc_q == SEED) && !restart_q);
    // R9
    scratch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && we && tgt == TGT_SCRATCH && size == SZ_WORD) |=> $stable(scr_q));
    // R6
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(accept && we && tgt == TGT_DATA) && !restart_q) |=> $stable(crc_q));
endmodule

// File: rtl/crc_mmio_unit.sv
module crc_mmio_unit
    import crc_mmio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be,
    output logic [31:0]       rdata,
    output logic              ready
);
    logic        accept;
    tgt_e        tgt;
    acc_size_e   size;
    logic [31:0] crc_q, crc_next;

    crc_bus_ctrl #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .be(be),
        .accept(accept), .tgt(tgt), .size(size), .ready(ready)
    );

    crc_lane_engine #(.W(WORD_W), .POLY(CRC_POLY), .NLANES(3)) u_eng (
        .crc_in(crc_q), .data_in(wdata), .size(size), .crc_out(crc_next)
    );

    crc_reg_store #(.W(WORD_W), .SEED(CRC_SEED)) u_regs (
        .clk(clk), .rst_n(rst_n), .accept(accept), .we(we), .tgt(tgt),
        .size(size), .wdata(wdata), .crc_next(crc_next), .crc_q(crc_q),
        .rdata(rdata)
    );
endmodule

// File: tb/sim_crc_mmio_unit.sv
module sim_crc_mmio_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic        ready;

    crc_mmio_unit u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic        chk;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int issued = 0;
    logic prev_ready = 1'b0;
    logic [31:0] model = 32'hFFFFFFFF;

    function automatic logic [31:0] ref_step(input logic [31:0] c,
                                             input logic [31:0] d, input int n);
        logic [31:0] r;
        logic [31:0] m;
        m = (n == 32) ? 32'hFFFFFFFF : ((32'd1 << n) - 1);
        r = c ^ ((d & m) << (32 - n));
        for (int k = 0; k < n; k++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one item per response pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ready && ready) check("R2 ready longer than one cycle", 32'd1, 32'd0);
            if (ready) begin
                pulses++;
                if (sb_q.size() == 0) check("R2 unexpected ready", 32'd1, 32'd0);
                else begin
                    item_t it;
                    it = sb_q.pop_front();
                    if (it.chk) check(it.tag, rdata, it.exp);
                end
            end
            prev_ready = ready;
        end
    end

    task automatic access(input logic w, input logic [3:0] a, input logic [3:0] b,
                          input logic [31:0] d, input logic c, input logic [31:0] e,
                          input string tag);
        item_t it;
        it.chk = c; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        issued++;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; be = b; wdata = d;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d);
        access(1'b1, a, b, d, 1'b0, 32'd0, "write");
    endtask

    task automatic rd(input logic [3:0] a, input logic [3:0] b, input logic [31:0] e,
                      input string tag);
        access(1'b0, a, b, 32'd0, 1'b1, e, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(4'h0, 4'b1111, 32'hFFFFFFFF, "R1 data reset");
        rd(4'h4, 4'b1111, 32'h0, "R1 scratch reset");
        rd(4'h8, 4'b1111, 32'h0, "R1 ctrl reset");

        // R3 word updates
        wr(4'h0, 4'b1111, 32'h12345678);
        model = ref_step(model, 32'h12345678, 32);
        rd(4'h0, 4'b1111, model, "R3 word update");
        wr(4'h0, 4'b1111, 32'h00000000);
        model = ref_step(model, 32'h0, 32);
        rd(4'h0, 4'b1111, model, "R3 second word update");

        // R8 restart
        wr(4'h8, 4'b1111, 32'h1);
        model = 32'hFFFFFFFF;
        rd(4'h0, 4'b1111, 32'hFFFFFFFF, "R8 restart reloads");
        rd(4'h8, 4'b1111, 32'h0, "R8 bit self-clears");

        // R4 byte check string
        for (int i = 0; i < 9; i++) begin
            wr(4'h0, 4'b0001, 32'hA5A5A500 | (32'h31 + i));
            model = ref_step(model, 32'h31 + i, 8);
        end
        rd(4'h0, 4'b1111, 32'h0376E6E7, "R4 byte string check value");
        check("R4 model agrees with check value", model, 32'h0376E6E7);

        // R4 half-word with upper garbage
        wr(4'h0, 4'b0011, 32'hDEADABCD);
        model = ref_step(model, 32'hABCD, 16);
        rd(4'h0, 4'b1111, model, "R4 half-word update");

        // R5 narrow reads
        rd(4'h0, 4'b0011, {16'h0, model[15:0]}, "R5 half read");
        rd(4'h0, 4'b0001, {24'h0, model[7:0]}, "R5 byte read");

        // R6 invalid size
        wr(4'h0, 4'b1100, 32'h55AA55AA);
        rd(4'h0, 4'b1111, model, "R6 invalid-size write ignored");
        rd(4'h0, 4'b0110, 32'h0, "R6 invalid-size read zero");

        // R7 scratch
        wr(4'h4, 4'b1111, 32'hCAFEF00D);
        rd(4'h4, 4'b1111, 32'hCAFEF00D, "R7 scratch word");
        wr(4'h4, 4'b0001, 32'h00000011);
        rd(4'h4, 4'b1111, 32'hCAFEF00D, "R7 narrow scratch write ignored");
        rd(4'h4, 4'b0011, 32'h0, "R7 narrow scratch read zero");

        // R9 scratch survives restart
        wr(4'h8, 4'b1111, 32'h1);
        model = 32'hFFFFFFFF;
        rd(4'h4, 4'b1111, 32'hCAFEF00D, "R9 scratch after restart");
        rd(4'h0, 4'b1111, 32'hFFFFFFFF, "R8 restart again");

        // R10 unmapped / misaligned
        wr(4'hC, 4'b1111, 32'h00000005);
        rd(4'hC, 4'b1111, 32'h0, "R10 unmapped read");
        rd(4'h1, 4'b1111, 32'h0, "R10 misaligned read");
        wr(4'h5, 4'b1111, 32'h0);
        rd(4'h4, 4'b1111, 32'hCAFEF00D, "R10 misaligned write ignored");
        wr(4'h1, 4'b1111, 32'h0BADBEEF);
        rd(4'h0, 4'b1111, model, "R10 misaligned data write ignored");

        // R2 request held through the response cycle
        begin
            item_t it;
            it.chk = 1'b0; it.exp = 32'd0; it.tag = "write";
            sb_q.push_back(it);
            issued++;
            @(negedge clk);
            req = 1'b1; we = 1'b1; addr = 4'h0; be = 4'b1111; wdata = 32'h01020304;
            @(negedge clk);
            @(negedge clk);
            req = 1'b0;
            @(negedge clk);
            model = ref_step(model, 32'h01020304, 32);
        end
        rd(4'h0, 4'b1111, model, "R2 held request taken once");

        repeat (3) @(negedge clk);
        check("R2 one pulse per access", pulses, issued);
        check("R2 scoreboard drained", sb_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule